// File: doc/BRIEF.md
# SPI-Mode SD Command Front End

This block sits between a byte-wide SPI slave and the command side of an SD card model or controller. Each SPI transfer hands it one received byte and it returns one byte. While idle it waits for a command. A command is six bytes: a start byte whose low six bits give the command index, four argument bytes sent most significant first, and a check byte. When the check byte arrives the block raises a one-cycle request carrying the index and argument. The card answers in that same cycle with an accept flag and a 32-bit word. The block then streams the response in SPI form: R1, the two-byte R2 status, the five-byte R3/R7 reply, or R1b with its trailing busy byte.

Two more tokens are handled while the block waits for a command. A write start token hands the link to a separate write data engine. A stop token issues a stop-transmission request and answers with a ready or busy byte. After a response, if the card reports read data pending, the block hands the link to the read data engine. Either engine returns control with a done pulse.

Top module: `sdspi_cmd_front`

## Requirements
- R1: In the command-wait state a received 0xFF answers 0xFF and the block keeps waiting.
- R2: Any other non-token byte in the command-wait state starts a command with index = byte[5:0]. The next four bytes form the argument, most significant byte first. One cycle after the sixth byte is taken, `req_valid` pulses for exactly one cycle carrying `req_cmd` and `req_arg`.
- R3: The check byte is not verified. Every byte of the command and exactly one following filler byte answer 0xFF, and the first response byte comes back on the next transfer.
- R4: If the card rejects the request (`card_ok` low), the response is the single byte 0x04.
- R5: For commands 8 and 58 that the card accepts, the response is five bytes: 0x01 followed by `card_word` with its most significant byte first.
- R6: Command 13 returns the two status bytes, high byte first. Every other accepted command returns only the high status byte.
- R7: The high status byte is built from these card word bits: bit0 = (card bits 12:9 < 4), bit1 = bit13, bit2 = bit22, bit3 = bit23, bit4 = bit28, bit5 = bit30, bit6 = (low status byte nonzero), bit7 = 0.
- R8: The low status byte is built from these card word bits: bit0 = bit25, bit1 = bit24|bit15, bit2 = bit19, bit3 = bit20, bit4 = bit21, bit5 = bit26, bit6 = bit27, bit7 = bit31|bit16.
- R9: After its response, an accepted command 28, 29 or 38 returns one 0xFF byte and goes back to waiting for a command, even when `data_ready` is high.
- R10: In the command-wait state, 0xFE or 0xFC answers 0xFF and pulses `wr_start` one cycle later.
- R11: In the command-wait state, 0xFD answers 0xFF and raises a request with command 12 and argument 0. The next byte answers 0x00 if the card is busy (`card_ok` low) and 0xFF if it is ready.
- R12: The byte after a response answers 0xFF. If `data_ready` is high (and R9 does not apply), `rd_start` pulses with that byte. Otherwise the block returns to command wait.
- R13: Synchronous reset, or `cs_n` high, returns the block to command wait and discards a partly received command. While `cs_n` is high no byte is taken and `tx_valid` stays low.
- R14: After a hand-off the block answers nothing (`tx_valid` low) and ignores bytes until `eng_done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | Registered: reply byte for the previous transfer |
| tx_byte | output | 8 | Reply byte |
| req_valid | output | 1 | One-cycle request to the card |
| req_cmd | output | 6 | Request command index |
| req_arg | output | 32 | Request argument |
| card_ok | input | 1 | Card accepts the request (or is ready, for stop), valid while req_valid |
| card_word | input | 32 | Card status or long response, valid while req_valid |
| data_ready | input | 1 | Card has read data pending |
| wr_start | output | 1 | Pulse: hand the link to the write data engine |
| rd_start | output | 1 | Pulse: hand the link to the read data engine |
| eng_done | input | 1 | Data engine returns the link |

## Verification
The reply to a byte appears on `tx_valid`/`tx_byte` one cycle after the edge that takes the byte. The bench drives each byte on a falling edge and reads the reply on the next falling edge, so bytes run back to back. `req_valid` is checked at the sample point right after the check byte or stop token. `wr_start` and `rd_start` are checked right after the token or tail byte that causes them. Because the next byte always arrives in the same cycle as the card's answer, the bench covers the path where the card's reply is used in the same cycle it is captured.

// File: rtl/sdspi_pkg.sv
package sdspi_pkg;
  typedef enum logic [2:0] {
    ST_WAIT,
    ST_ARG,
    ST_NCR,
    ST_RESP,
    ST_HAND
  } st_e;

  localparam int RESP_BYTES = 5;
  localparam logic [7:0] BYTE_IDLE   = 8'hFF;
  localparam logic [7:0] TOK_SINGLE  = 8'hFE;
  localparam logic [7:0] TOK_MULTI   = 8'hFC;
  localparam logic [7:0] TOK_STOP    = 8'hFD;
  localparam logic [7:0] RESP_REJECT = 8'h04;
  localparam logic [7:0] RESP_IFCOND = 8'h01;
  localparam logic [5:0] CMD_STOP    = 6'd12;
endpackage

// File: rtl/sdspi_arg_shift.sv
module sdspi_arg_shift #(
  parameter int ARG_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   shift_en,
  input  logic [7:0]             din,
  output logic [ARG_BYTES*8-1:0] arg
);
  localparam int ARG_W = ARG_BYTES * 8;

  always_ff @(posedge clk) begin
    if (rst) begin
      arg <= '0;
    end else if (shift_en) begin
      arg <= {arg[ARG_W-9:0], din};
    end
  end
endmodule

// File: rtl/sdspi_resp_fmt.sv
module sdspi_resp_fmt
  import sdspi_pkg::*;
#(
  parameter int LEN_W = 3
) (
  input  logic [5:0]              cmd_idx,
  input  logic                    is_stop,
  input  logic                    card_ok,
  input  logic [31:0]             card_word,
  output logic [RESP_BYTES*8-1:0] bytes,
  output logic [LEN_W-1:0]        len,
  output logic                    r1b
);
  logic [7:0] lo, hi;

  // Status word translation from the card's native 32-bit status
  always_comb begin
    lo[0] = card_word[25];
    lo[1] = card_word[24] | card_word[15];
    lo[2] = card_word[19];
    lo[3] = card_word[20];
    lo[4] = card_word[21];
    lo[5] = card_word[26];
    lo[6] = card_word[27];
    lo[7] = card_word[31] | card_word[16];
    hi[0] = (card_word[12:9] < 4'd4);
    hi[1] = card_word[13];
    hi[2] = card_word[22];
    hi[3] = card_word[23];
    hi[4] = card_word[28];
    hi[5] = card_word[30];
    hi[6] = |lo;
    hi[7] = 1'b0;
  end

  always_comb begin
    bytes = '0;
    len   = LEN_W'(1);
    r1b   = 1'b0;
    if (is_stop) begin
      bytes[RESP_BYTES*8-1 -: 8] = card_ok ? BYTE_IDLE : 8'h00;
    end else if (!card_ok) begin
      bytes[RESP_BYTES*8-1 -: 8] = RESP_REJECT;
    end else if (cmd_idx == 6'd8 || cmd_idx == 6'd58) begin
      bytes = {RESP_IFCOND, card_word};
      len   = LEN_W'(RESP_BYTES);
    end else begin
      bytes[RESP_BYTES*8-1 -: 16] = {hi, lo};
      len = (cmd_idx == 6'd13) ? LEN_W'(2) : LEN_W'(1);
      r1b = (cmd_idx == 6'd28) || (cmd_idx == 6'd29) || (cmd_idx == 6'd38);
    end
  end
endmodule

// File: rtl/sdspi_cmd_front.sv
module sdspi_cmd_front
  import sdspi_pkg::*;
#(
  parameter int ARG_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cs_n,
  input  logic                   rx_valid,
  input  logic [7:0]             rx_byte,
  output logic                   tx_valid,
  output logic [7:0]             tx_byte,
  output logic                   req_valid,
  output logic [5:0]             req_cmd,
  output logic [ARG_BYTES*8-1:0] req_arg,
  input  logic                   card_ok,
  input  logic [31:0]            card_word,
  input  logic                   data_ready,
  output logic                   wr_start,
  output logic                   rd_start,
  input  logic                   eng_done
);
  localparam int ARG_W = ARG_BYTES * 8;
  localparam int CNT_W = $clog2(ARG_BYTES + 1);
  localparam int RSP_W = RESP_BYTES * 8;
  localparam int LEN_W = $clog2(RESP_BYTES + 1);

  st_e              st;
  logic [CNT_W-1:0] cnt;
  logic [5:0]       cmd_q;
  logic             stop_q, req_q, r1b_q;
  logic [LEN_W-1:0] rem;
  logic [RSP_W-1:0] buf_q;
  logic [ARG_W-1:0] arg;
  logic             take;

  logic [RSP_W-1:0] f_bytes, cur_bytes;
  logic [LEN_W-1:0] f_len, cur_rem;
  logic             f_r1b, cur_r1b;

  assign take = rx_valid && !cs_n;

  sdspi_arg_shift #(.ARG_BYTES(ARG_BYTES)) u_arg (
    .clk      (clk),
    .rst      (rst),
    .shift_en (take && st == ST_ARG && cnt != CNT_W'(ARG_BYTES)),
    .din      (rx_byte),
    .arg      (arg)
  );

  sdspi_resp_fmt #(.LEN_W(LEN_W)) u_fmt (
    .cmd_idx   (cmd_q),
    .is_stop   (stop_q),
    .card_ok   (card_ok),
    .card_word (card_word),
    .bytes     (f_bytes),
    .len       (f_len),
    .r1b       (f_r1b)
  );

  // The card answers in the request cycle; a byte taken in that same cycle uses it directly
  assign cur_bytes = req_q ? f_bytes : buf_q;
  assign cur_rem   = req_q ? f_len   : rem;
  assign cur_r1b   = req_q ? f_r1b   : r1b_q;

  assign req_valid = req_q;
  assign req_cmd   = stop_q ? CMD_STOP : cmd_q;
  assign req_arg   = stop_q ? '0 : arg;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_WAIT;
      cnt      <= '0;
      cmd_q    <= '0;
      stop_q   <= 1'b0;
      req_q    <= 1'b0;
      r1b_q    <= 1'b0;
      rem      <= '0;
      buf_q    <= '0;
      tx_valid <= 1'b0;
      tx_byte  <= BYTE_IDLE;
      wr_start <= 1'b0;
      rd_start <= 1'b0;
    end else begin
      req_q    <= 1'b0;
      wr_start <= 1'b0;
      rd_start <= 1'b0;
      tx_valid <= 1'b0;
      if (req_q) begin
        buf_q <= f_bytes;
        rem   <= f_len;
        r1b_q <= f_r1b;
      end
      if (cs_n) begin
        st  <= ST_WAIT;
        cnt <= '0;
        rem <= '0;
      end else begin
        unique case (st)
          ST_WAIT: if (rx_valid) begin
            tx_valid <= 1'b1;
            tx_byte  <= BYTE_IDLE;
            if (rx_byte == TOK_SINGLE || rx_byte == TOK_MULTI) begin
              wr_start <= 1'b1;
              st       <= ST_HAND;
            end else if (rx_byte == TOK_STOP) begin
              stop_q <= 1'b1;
              req_q  <= 1'b1;
              st     <= ST_RESP;
            end else if (rx_byte != BYTE_IDLE) begin
              cmd_q  <= rx_byte[5:0];
              stop_q <= 1'b0;
              cnt    <= '0;
              st     <= ST_ARG;
            end
          end
          ST_ARG: if (rx_valid) begin
            tx_valid <= 1'b1;
            tx_byte  <= BYTE_IDLE;
            if (cnt == CNT_W'(ARG_BYTES)) begin
              req_q <= 1'b1;
              cnt   <= '0;
              st    <= ST_NCR;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_NCR: if (rx_valid) begin
            tx_valid <= 1'b1;
            tx_byte  <= BYTE_IDLE;
            st       <= ST_RESP;
          end
          ST_RESP: if (rx_valid) begin
            tx_valid <= 1'b1;
            if (cur_rem != '0) begin
              tx_byte <= cur_bytes[RSP_W-1 -: 8];
              buf_q   <= cur_bytes << 8;
              rem     <= cur_rem - 1'b1;
            end else begin
              tx_byte <= BYTE_IDLE;
              if (cur_r1b) begin
                st <= ST_WAIT;
              end else if (data_ready) begin
                rd_start <= 1'b1;
                st       <= ST_HAND;
              end else begin
                st <= ST_WAIT;
              end
            end
          end
          ST_HAND: if (eng_done) st <= ST_WAIT;
          default: st <= ST_WAIT;
        endcase
      end
    end
  end
endmodule

// File: rtl/sdspi_cmd_front_chk.sv
module sdspi_cmd_front_chk
  import sdspi_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       rx_valid,
  input logic [7:0] rx_byte,
  input logic       tx_valid,
  input logic [7:0] tx_byte,
  input logic       req_valid,
  input logic [5:0] req_cmd,
  input logic       wr_start,
  input st_e        st
);
  logic take_wait;
  assign take_wait = rx_valid && !cs_n && st == ST_WAIT;

  AST_NULL_ECHO: assert property (@(posedge clk) disable iff (rst)
    (take_wait && rx_byte == 8'hFF) |=> (tx_valid && tx_byte == 8'hFF)); // R1
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid); // R2
  AST_WR_HANDOFF: assert property (@(posedge clk) disable iff (rst)
    (take_wait && (rx_byte == 8'hFE || rx_byte == 8'hFC)) |=> wr_start); // R10
  AST_STOP_REQ: assert property (@(posedge clk) disable iff (rst)
    (take_wait && rx_byte == 8'hFD) |=> (req_valid && req_cmd == 6'd12)); // R11
  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !tx_valid); // R13
  AST_HAND_SILENT: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HAND) |=> !tx_valid); // R14
endmodule

bind sdspi_cmd_front sdspi_cmd_front_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_n      (cs_n),
  .rx_valid  (rx_valid),
  .rx_byte   (rx_byte),
  .tx_valid  (tx_valid),
  .tx_byte   (tx_byte),
  .req_valid (req_valid),
  .req_cmd   (req_cmd),
  .wr_start  (wr_start),
  .st        (st)
);

// File: tb/tb_sdspi_cmd_front.sv
module tb_sdspi_cmd_front;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = 8'hFF;
  logic        tx_valid;
  logic [7:0]  tx_byte;
  logic        req_valid;
  logic [5:0]  req_cmd;
  logic [31:0] req_arg;
  logic        card_ok = 1'b1;
  logic [31:0] card_word = '0;
  logic        data_ready = 1'b0;
  logic        wr_start, rd_start;
  logic        eng_done = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdspi_cmd_front dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .req_valid(req_valid),
    .req_cmd(req_cmd), .req_arg(req_arg), .card_ok(card_ok),
    .card_word(card_word), .data_ready(data_ready), .wr_start(wr_start),
    .rd_start(rd_start), .eng_done(eng_done)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one transfer: drive at a falling edge, read the reply at the next one
  task automatic xfer(input logic [7:0] b, output logic v, output logic [7:0] o);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    v = tx_valid;
    o = tx_byte;
    rx_valid = 1'b0;
  endtask

  task automatic xfer_exp(input logic [7:0] b, input logic [7:0] e, input string tag);
    logic v;
    logic [7:0] o;
    xfer(b, v, o);
    chk(v === 1'b1 && o === e, tag, {v, o}, {1'b1, e});
  endtask

  task automatic xfer_silent(input logic [7:0] b, input string tag);
    logic v;
    logic [7:0] o;
    xfer(b, v, o);
    chk(v === 1'b0, tag, v, 0);
  endtask

  function automatic logic [15:0] exp_status(input logic [31:0] w);
    logic [7:0] h, l;
    l = {w[31] | w[16], w[27], w[26], w[21], w[20], w[19], w[24] | w[15], w[25]};
    h = {1'b0, |l, w[30], w[28], w[23], w[22], w[13], (w[12:9] < 4'd4)};
    return {h, l};
  endfunction

  // expected response bytes, first byte in the top position
  task automatic expect_resp(input logic [5:0] idx, input logic ok, input logic [31:0] w,
                             output int n, output logic [39:0] e);
    logic [15:0] s;
    s = exp_status(w);
    if (!ok) begin n = 1; e = {8'h04, 32'h0}; end
    else if (idx == 6'd8 || idx == 6'd58) begin n = 5; e = {8'h01, w}; end
    else if (idx == 6'd13) begin n = 2; e = {s, 24'h0}; end
    else begin n = 1; e = {s[15:8], 32'h0}; end
  endtask

  task automatic run_cmd(input logic [7:0] cbyte, input logic [31:0] arg, input string tag);
    int n;
    logic [39:0] e;
    expect_resp(cbyte[5:0], card_ok, card_word, n, e);
    xfer_exp(cbyte, 8'hFF, {"R3 cmd byte ", tag});
    for (int k = 0; k < 4; k++) xfer_exp(arg[31-8*k -: 8], 8'hFF, {"R3 arg byte ", tag});
    xfer_exp(8'h95, 8'hFF, {"R3 check byte ", tag});
    chk(req_valid === 1'b1 && req_cmd === cbyte[5:0] && req_arg === arg,
        {"R2 request ", tag}, {req_valid, req_cmd, req_arg}, {1'b1, cbyte[5:0], arg});
    xfer_exp(8'hFF, 8'hFF, {"R3 filler ", tag});
    for (int k = 0; k < n; k++) xfer_exp(8'hFF, e[39-8*k -: 8], {"R5/R6/R7/R8 resp ", tag});
    xfer_exp(8'hFF, 8'hFF, {"R12 tail ", tag});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic v;
    logic [7:0] o;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    chk(tx_valid === 1'b0 && req_valid === 1'b0 && wr_start === 1'b0 && rd_start === 1'b0,
        "R13 reset outputs", {tx_valid, req_valid, wr_start, rd_start}, 0);
    xfer_exp(8'hFF, 8'hFF, "R1 null byte");
    xfer_exp(8'hFF, 8'hFF, "R1 null byte repeat");

    // sweep every command index with a varying card word
    for (int i = 0; i < 64; i++) begin
      card_ok   = 1'b1;
      card_word = 32'h9E3779B9 * (i + 1);
      run_cmd(8'h40 | 8'(i), 32'h01020304 * (i + 3), $sformatf("sweep cmd%0d", i));
      xfer_exp(8'hFF, 8'hFF, "R1 null after command");
    end

    // R8/R7 single-bit walk through two-byte status, current state at the boundary
    for (int b = 0; b < 32; b++) begin
      card_word = (32'h1 << b) | (32'd4 << 9);
      run_cmd(8'h4D, 32'hA5A5_0000 + 32'(b), $sformatf("R7 R8 status bit %0d", b));
    end
    card_word = 32'd3 << 9;
    run_cmd(8'h4D, 32'h0, "R7 idle state 3");
    card_word = 32'd4 << 9;
    run_cmd(8'h4D, 32'h0, "R7 idle state 4");

    // R2 index taken from low six bits of a byte with top bits set
    card_word = 32'h0;
    run_cmd(8'h8A, 32'hDEADBEEF, "R2 index low bits");

    // R4 rejection
    card_ok = 1'b0;
    card_word = 32'hFFFF_FFFF;
    run_cmd(8'h48, 32'h1AA, "R4 reject cmd8");
    run_cmd(8'h4D, 32'h0, "R4 reject cmd13");
    card_ok = 1'b1;

    // R9 busy-response commands skip the read hand-off
    data_ready = 1'b1;
    card_word = 32'h0000_0900;
    run_cmd(8'h5C, 32'h0, "R9 cmd28");
    chk(rd_start === 1'b0, "R9 no read start", rd_start, 0);
    xfer_exp(8'hFF, 8'hFF, "R9 back in command wait");
    run_cmd(8'h66, 32'h0, "R9 cmd38");
    chk(rd_start === 1'b0, "R9 no read start cmd38", rd_start, 0);
    xfer_exp(8'hFF, 8'hFF, "R9 back in command wait 38");

    // R12 read hand-off and R14 silence until done
    run_cmd(8'h51, 32'h200, "R12 cmd17");
    chk(rd_start === 1'b1, "R12 read start", rd_start, 1);
    xfer_silent(8'h40, "R14 ignored during read");
    xfer_silent(8'hFD, "R14 token ignored during read");
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
    xfer_exp(8'hFF, 8'hFF, "R14 back after done");
    data_ready = 1'b0;

    // R10 write tokens
    xfer_exp(8'hFE, 8'hFF, "R10 token FE");
    chk(wr_start === 1'b1 && req_valid === 1'b0, "R10 write start FE", {wr_start, req_valid}, 2);
    xfer_silent(8'h51, "R14 ignored during write");
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
    xfer_exp(8'hFC, 8'hFF, "R10 token FC");
    chk(wr_start === 1'b1, "R10 write start FC", wr_start, 1);
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
    xfer_exp(8'hFF, 8'hFF, "R10 back after write");

    // R11 stop token, ready then busy
    card_ok = 1'b1;
    xfer_exp(8'hFD, 8'hFF, "R11 stop token");
    chk(req_valid === 1'b1 && req_cmd === 6'd12 && req_arg === 32'h0, "R11 stop request",
        {req_valid, req_cmd, req_arg}, {1'b1, 6'd12, 32'h0});
    xfer_exp(8'hFF, 8'hFF, "R11 ready byte");
    xfer_exp(8'hFF, 8'hFF, "R11 tail");
    card_ok = 1'b0;
    xfer_exp(8'hFD, 8'hFF, "R11 stop token busy");
    xfer_exp(8'hFF, 8'h00, "R11 busy byte");
    xfer_exp(8'hFF, 8'hFF, "R11 tail busy");
    card_ok = 1'b1;

    // R13 deselect mid-command
    xfer_exp(8'h51, 8'hFF, "R13 partial cmd");
    xfer_exp(8'h11, 8'hFF, "R13 partial arg");
    cs_n = 1'b1;
    xfer(8'h22, v, o);
    chk(v === 1'b0, "R13 no reply while deselected", v, 0);
    cs_n = 1'b0;
    card_word = 32'h0040_0000;
    run_cmd(8'h51, 32'hCAFE_F00D, "R13 after deselect");

    // R13 reset mid-command
    xfer_exp(8'h58, 8'hFF, "R13 partial before reset");
    xfer_exp(8'h33, 8'hFF, "R13 partial arg before reset");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(tx_valid === 1'b0, "R13 reset clears reply", tx_valid, 0);
    run_cmd(8'h7A, 32'h1234_5678, "R13 after reset cmd58");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule